// File: doc/BRIEF.md
# Fractional baud tick generator

This block turns a fast system clock into the timing strobes a serial transceiver needs. It emits a single-cycle pulse at sixteen times the line rate, which paces the oversampling receiver, and optionally a second pulse once per bit for the transmitter. The rate is set by a 22-bit divisor that holds a 16-bit whole number of clocks and a 6-bit binary fraction in steps of 1/64.

Each oversample period lasts either the whole part or one clock more. A 6-bit phase accumulator adds the fraction once per tick. Its carry lengthens the following period, so the mean tick spacing equals the full fractional divisor. Standard line rates can therefore be reached with small error whenever the system clock is well above sixteen times the line rate.

Software-facing registers and the clock source sit outside the block. The divisor port is compared against its registered copy every cycle, so any write restarts the timing cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: The divisor port carries the whole part W in bits [21:6] and the fraction F in bits [5:0], where F counts 1/64 of a clock.
- R2: Whenever W is nonzero, consecutive oversample ticks are W or W+1 clocks apart.
- R3: After a restart, tick number n (counting from 0) falls exactly (n+1)*W + floor(n*F/64) - 1 clocks after the first running cycle.
- R4: Any 64 consecutive tick intervals add up to exactly 64*W + F clocks.
- R5: A whole part of zero holds the generator stopped, and neither tick output is ever high.
- R6: While en is low no tick is produced. Raising en restarts the timing with a cleared accumulator, and the running cycle in which en is first seen high counts as index 0.
- R7: A divisor value that differs from the held one produces no tick in that cycle. Timing then restarts from index 0 in the following cycle with a cleared accumulator.
- R8: The bit tick is high only together with an oversample tick, on ticks 15, 31, 47 and so on after a restart. It is held low when the bit tick option is off.
- R9: While rst_n is low, both tick outputs are low and all counters are cleared.
- R10: With W=1 and F=0, the oversample tick is high on every running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears and halts the generator |
| div_i | input | 22 | Divisor: whole part [21:6], fraction [5:0] |
| tick_16x | output | 1 | One-cycle oversample strobe |
| tick_1x | output | 1 | One-cycle bit strobe on every 16th oversample strobe |

## Verification
On every cycle, the assertions check that no tick is produced while the block is disabled, while the whole part is zero, or in the cycle a new divisor arrives. They also check that every interval between ticks is W or W+1 clocks, and that a bit tick never appears without an oversample tick. The exact placement of each tick, the 64-tick sum, the fraction's effect on the dither pattern and the bit tick's phase after a restart can only be shown by the bench. It sweeps every fraction for small whole parts and compares each cycle against the closed-form tick times.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int unsigned BG_INT_W  = 16;
   localparam int unsigned BG_FRAC_W = 6;
   localparam int unsigned BG_OVS    = 16;

   // width of a counter that can hold 0..n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bg_div_capture.sv
module bg_div_capture #(
   parameter int unsigned DIV_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic [DIV_W-1:0] div_q,
   output logic             chg
);
   assign chg = (div_i != div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_i;
   end
endmodule

// File: rtl/bg_phase_core.sv
module bg_phase_core #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [INT_W-1:0]  int_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              tick_o
);
   localparam int unsigned LEN_W = INT_W + 1;

   logic [INT_W-1:0]  cnt;
   logic [FRAC_W-1:0] acc;
   logic              extra;
   logic [LEN_W-1:0]  len;
   logic [FRAC_W:0]   sum;

   assign len    = {1'b0, int_i} + {{INT_W{1'b0}}, extra};
   assign sum    = {1'b0, acc} + {1'b0, frac_i};
   assign tick_o = run && ({1'b0, cnt} == (len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc   <= '0;
         extra <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         acc   <= '0;
         extra <= 1'b0;
      end else if (tick_o) begin
         cnt   <= '0;
         acc   <= sum[FRAC_W-1:0];
         extra <= sum[FRAC_W];
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // interval monitor for the spacing property
   logic [LEN_W-1:0] gap;
   logic             seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (!run) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (tick_o) begin
         gap  <= {{INT_W{1'b0}}, 1'b1};
         seen <= 1'b1;
      end else if (gap != {LEN_W{1'b1}}) begin
         gap  <= gap + 1'b1;
      end
   end

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && seen) |-> ((gap == {1'b0, int_i}) || (gap == ({1'b0, int_i} + 1'b1))))
      else $error("tick interval outside W..W+1");
endmodule

// File: rtl/bg_ovs_divider.sv
module bg_ovs_divider
   import baud_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter bit          BIT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick_i,
   output logic bit_o
);
   localparam int unsigned OW = cnt_width(OVS);
   localparam logic [OW-1:0] LAST = OW'(OVS - 1);

   generate
      if (BIT_EN) begin : g_count
         logic [OW-1:0] oc;
         assign bit_o = tick_i && (oc == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      oc <= '0;
            else if (!run)   oc <= '0;
            else if (tick_i) oc <= (oc == LAST) ? '0 : oc + 1'b1;
         end
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, run, tick_i};
         assign bit_o = 1'b0;
      end
   endgenerate

   p_bit_in_ovs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_o |-> tick_i)
      else $error("bit tick without oversample tick");
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import baud_pkg::*;
#(
   parameter int unsigned INT_W       = BG_INT_W,
   parameter int unsigned FRAC_W      = BG_FRAC_W,
   parameter int unsigned OVS         = BG_OVS,
   parameter bit          BIT_TICK_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [INT_W+FRAC_W-1:0]   div_i,
   output logic                      tick_16x,
   output logic                      tick_1x
);
   localparam int unsigned DIV_W = INT_W + FRAC_W;

   initial begin
      a_int_w:  assert (INT_W >= 2)  else $error("INT_W too small");
      a_frac_w: assert (FRAC_W >= 1) else $error("FRAC_W too small");
      a_ovs:    assert (OVS >= 2)    else $error("OVS too small");
   end

   logic [DIV_W-1:0]  div_q;
   logic              chg;
   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic              run;

   bg_div_capture #(.DIV_W(DIV_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .div_i (div_i),
      .div_q (div_q),
      .chg   (chg)
   );

   assign int_q  = div_q[DIV_W-1:FRAC_W];
   assign frac_q = div_q[FRAC_W-1:0];
   assign run    = en && (int_q != '0) && !chg;

   bg_phase_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .int_i  (int_q),
      .frac_i (frac_q),
      .tick_o (tick_16x)
   );

   bg_ovs_divider #(.OVS(OVS), .BIT_EN(BIT_TICK_EN)) u_ovs (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick_i (tick_16x),
      .bit_o  (tick_1x)
   );

   p_change_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chg |-> !tick_16x)
      else $error("tick in divisor change cycle");

   p_disable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!tick_16x && !tick_1x))
      else $error("tick while disabled");

   p_zero_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_i[DIV_W-1:FRAC_W] == '0) |-> !tick_16x)
      else $error("tick with zero whole part");
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [21:0] div = '0;
   logic        tick_16x, tick_1x;
   int          n_tests = 0;
   int          n_fail  = 0;

   always #4 clk = ~clk;

   frac_baud_gen u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .div_i(div),
      .tick_16x(tick_16x), .tick_1x(tick_1x)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int t_of(input int w, input int f, input int n);
      return (n + 1) * w + (n * f) / 64 - 1;
   endfunction

   // R1 encoding: whole part in [21:6], fraction in [5:0]
   task automatic start_cfg(input int w, input int f);
      @(negedge clk);
      en  = 1'b0;
      div = '0;
      @(negedge clk);
      div = {w[15:0], f[5:0]};
      en  = 1'b1;
   endtask

   task automatic observe(input int w, input int f, input int nt);
      int times[80];
      int got = 0, n = 0, bad = 0, bad1 = 0, bad_gap = 0;
      int k_end = t_of(w, f, nt - 1);
      for (int k = 0; k <= k_end; k++) begin
         bit e, e1;
         @(posedge clk); #1;
         e  = (n < nt) && (k == t_of(w, f, n));
         e1 = e && ((n % 16) == 15);
         if (e) n++;
         if (tick_16x !== e) begin
            if (bad == 0) $display("  cycle %0d W=%0d F=%0d", k, w, f);
            bad++;
         end
         if (tick_1x !== e1) bad1++;
         if (tick_16x === 1'b1 && got < 80) begin
            times[got] = k;
            got++;
         end
      end
      chk(bad == 0, "R1/R3 tick placement", bad, 0);
      chk(bad1 == 0, "R8 bit tick placement", bad1, 0);
      for (int i = 1; i < got; i++)
         if (!((times[i] - times[i-1] == w) || (times[i] - times[i-1] == w + 1))) bad_gap++;
      chk(bad_gap == 0, "R2 interval W or W+1", bad_gap, 0);
      if (nt >= 66 && got >= 66) begin
         chk(times[64] - times[0] == 64 * w + f, "R4 64-tick sum", times[64] - times[0], 64 * w + f);
         chk(times[65] - times[1] == 64 * w + f, "R4 64-tick sum shifted", times[65] - times[1], 64 * w + f);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int cnt;
      // R9: reset holds outputs low even with a valid divisor
      en  = 1'b1;
      div = {16'd1, 6'd0};
      cnt = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (tick_16x !== 1'b0 || tick_1x !== 1'b0) cnt++;
      end
      chk(cnt == 0, "R9 outputs low in reset", cnt, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10 and the main sweep: all fractions for small whole parts
      for (int w = 1; w <= 3; w++)
         for (int f = 0; f < 64; f++) begin
            start_cfg(w, f);
            observe(w, f, 66);
         end
      start_cfg(1, 0);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(posedge clk); #1;
         if (tick_16x !== 1'b1) cnt++;
      end
      chk(cnt == 0, "R10 tick every cycle at W=1", cnt, 0);

      // larger whole parts
      start_cfg(7, 5);   observe(7, 5, 66);
      start_cfg(16, 0);  observe(16, 0, 66);
      start_cfg(16, 63); observe(16, 63, 66);
      start_cfg(13, 32); observe(13, 32, 66);

      // R7: divisor change mid-run
      start_cfg(3, 0);
      observe(3, 0, 5);
      @(negedge clk);
      div = {16'd5, 6'd32};
      #1;
      chk(tick_16x === 1'b0, "R7 no tick in change cycle", tick_16x, 0);
      observe(5, 32, 40);

      // R6: disable then re-enable
      start_cfg(4, 0);
      observe(4, 0, 3);
      @(negedge clk);
      en = 1'b0;
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
         @(posedge clk); #1;
         if (tick_16x !== 1'b0 || tick_1x !== 1'b0) cnt++;
      end
      chk(cnt == 0, "R6 no tick while disabled", cnt, 0);
      @(negedge clk);
      en = 1'b1;
      cnt = 0;
      for (int k = 0; k < 16; k++) begin
         if (k > 0) begin @(posedge clk); #1; end
         else #1;
         if (tick_16x !== ((k % 4) == 3)) cnt++;
      end
      chk(cnt == 0, "R6 restart timing after enable", cnt, 0);

      // R5: zero whole part holds generator stopped
      @(negedge clk);
      en  = 1'b0;
      div = {16'd0, 6'd20};
      @(negedge clk);
      en  = 1'b1;
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         @(posedge clk); #1;
         if (tick_16x !== 1'b0 || tick_1x !== 1'b0) cnt++;
      end
      chk(cnt == 0, "R5 stopped at zero whole part", cnt, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule